// File: doc/BRIEF.md
# Synchronous Buck PWM Gate Logic

This block turns a duty command into the two gate enables of a synchronous step-down power stage. A free-running counter splits time into switching periods of a fixed number of system-clock cycles, derived from the clock rate and the target switching rate. At each period boundary the block samples the duty command, limits it to a legal on-time, and then drives the high-side enable for the first part of the period and the low-side enable for the rest. A programmable dead gap keeps both switches open at every handover.

A supervisor selects among three behaviours through a two-bit mode input: both switches open, low switch held closed, or normal modulation. Turning a switch off always happens on the next clock. Turning one on always waits out the dead gap. A one-cycle strobe marks the start of each period, so the supervisor can count switching cycles.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: `hs_en` and `ls_en` are never 1 in the same cycle.
- R2: When one enable falls and the other is next requested, the other rises only after exactly DEAD_CYC cycles with both enables at 0.
- R3: The period is PERIOD = CLK_HZ/SW_HZ cycles. `period_start` is 1 for one cycle per period, at position 0. The first strobe comes PERIOD cycles after the first clock edge with reset low.
- R4: `duty_cmd` is sampled only at the clock edge that starts a period. Changes at any other time have no effect on that period.
- R5: A command above MAXON = PERIOD*MAX_PCT/100 is treated as MAXON.
- R6: A command below MINON = ceil(PERIOD*MIN_PCT/100) deletes the pulse. `hs_en` stays 0 and `ls_en` stays 1 for the whole period.
- R7: Mode 2'b00 or 2'b11 (off) drives both enables to 0 from the next cycle.
- R8: Mode 2'b01 (low side forced) drives `hs_en` to 0 on the next cycle. `ls_en` rises once the dead gap has passed.
- R9: While `rst` (synchronous, active high) is 1, both enables and `period_start` are 0.
- R10: In mode 2'b10 (run), with sampled on-length L, the high-side request covers period positions 0..L-1 and the low-side request covers the rest. Each enable follows its request one cycle later, with turn-on delayed by R2. In steady state, `hs_en` is high for L-DEAD_CYC cycles per period and `ls_en` for PERIOD-L-DEAD_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00/11 off, 01 low side forced, 10 run |
| duty_cmd | input | CW = clog2(PERIOD+1) | Requested on-time in clock cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| period_start | output | 1 | One-cycle strobe at period position 0 |

## Verification
The assertions assume that `mode` and `duty_cmd` are synchronous to `clk`, and that DEAD_CYC is smaller than MINON, so that a legal pulse survives the dead gap. The stimulus changes the inputs only between clock edges. Commands are drawn from zero to a few counts above the period, which covers both clamps. Mode changes are rare random events plus directed handovers taken in the middle of a high-side pulse. A bench model follows every cycle so that the timing of every edge is compared.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  typedef enum logic [1:0] {
    DRV_OFF   = 2'b00,
    DRV_LOWON = 2'b01,
    DRV_RUN   = 2'b10,
    DRV_OFF_B = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PERIOD = 333,
  parameter int MAXON  = 299,
  parameter int MINON  = 34,
  parameter int CW     = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] duty_cmd,
  output logic [CW-1:0] pos,
  output logic [CW-1:0] on_len,
  output logic          pstart
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] MAXV = CW'(MAXON);
  localparam logic [CW-1:0] MINV = CW'(MINON);

  logic          wrap;
  logic [CW-1:0] lim_len;

  assign wrap = (pos == LAST);

  always_comb begin
    if (duty_cmd < MINV)      lim_len = '0;
    else if (duty_cmd > MAXV) lim_len = MAXV;
    else                      lim_len = duty_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      on_len <= '0;
      pstart <= 1'b0;
    end else begin
      pos    <= wrap ? '0 : pos + 1'b1;
      pstart <= wrap;
      if (wrap) on_len <= lim_len;
    end
  end

  // R5 R6
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (on_len == '0) || (on_len >= MINV && on_len <= MAXV));
  // R3
  strobe_pos_chk: assert property (@(posedge clk) disable iff (rst)
    pstart |-> (pos == '0));
  // R4
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pos != '0) |-> $stable(on_len));
endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_want,
  input  logic ls_want,
  output logic hs_q,
  output logic ls_q
);
  localparam int IW = $clog2(DEAD_CYC + 1);
  localparam logic [IW-1:0] GAP_LAST = IW'(DEAD_CYC - 1);
  localparam logic [IW-1:0] GAP_SAT  = IW'(DEAD_CYC);

  logic [IW-1:0] idle;
  logic          gap_done;

  assign gap_done = !hs_q && !ls_q && (idle >= GAP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
      idle <= '0;
    end else begin
      hs_q <= hs_want && (hs_q || gap_done);
      ls_q <= ls_want && !hs_want && (ls_q || gap_done);
      if (hs_q || ls_q)       idle <= '0;
      else if (idle < GAP_SAT) idle <= idle + 1'b1;
    end
  end

  // R1
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_q && ls_q));
  // R2
  hs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_q) |-> $past(!ls_q));
  // R2
  ls_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> $past(!hs_q));
  // R7
  off_chk: assert property (@(posedge clk) disable iff (rst)
    (!hs_want && !ls_want) |=> (!hs_q && !ls_q));
  // R8
  hs_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !hs_want |=> !hs_q);
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int SW_HZ    = 300_000,
  parameter int MAX_PCT  = 90,
  parameter int MIN_PCT  = 10,
  parameter int DEAD_CYC = 2,
  localparam int PERIOD  = CLK_HZ / SW_HZ,
  localparam int CW      = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] duty_cmd,
  output logic          hs_en,
  output logic          ls_en,
  output logic          period_start
);
  import pwm_gate_pkg::*;

  localparam int MAXON = (PERIOD * MAX_PCT) / 100;
  localparam int MINON = (PERIOD * MIN_PCT + 99) / 100;

  drv_mode_e     m;
  logic [CW-1:0] pos, on_len;
  logic          run, hs_req, ls_req;

  assign m      = drv_mode_e'(mode);
  assign run    = (m == DRV_RUN);
  assign hs_req = run && (pos < on_len);
  assign ls_req = (m == DRV_LOWON) || (run && !(pos < on_len));

  pwm_timebase #(
    .PERIOD(PERIOD), .MAXON(MAXON), .MINON(MINON), .CW(CW)
  ) u_tb (
    .clk(clk), .rst(rst), .duty_cmd(duty_cmd),
    .pos(pos), .on_len(on_len), .pstart(period_start)
  );

  pwm_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk(clk), .rst(rst), .hs_want(hs_req), .ls_want(ls_req),
    .hs_q(hs_en), .ls_q(ls_en)
  );

  // R6
  skip_chk: assert property (@(posedge clk) disable iff (rst)
    (run && on_len == '0) |=> !hs_en);
endmodule

// File: tb/sim_pwm_gate_ctrl.sv
`timescale 1ns/100ps
module sim_pwm_gate_ctrl;
  localparam int CLK_HZ = 200_000_000;
  localparam int SW_HZ  = 5_000_000;
  localparam int DT     = 3;
  localparam int PER    = CLK_HZ / SW_HZ;
  localparam int MAXON  = (PER * 90) / 100;
  localparam int MINON  = (PER * 10 + 99) / 100;
  localparam int CW     = $clog2(PER + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b10;
  logic [CW-1:0] duty = '0;
  logic hs, ls, ps;
  int total = 0, fails = 0;

  pwm_gate_ctrl #(.CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ), .DEAD_CYC(DT)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .duty_cmd(duty),
    .hs_en(hs), .ls_en(ls), .period_start(ps)
  );

  always #2.5 clk = ~clk;

  // reference model, stepped on the same edges as the design
  int m_pos, m_len, m_idle;
  bit m_hs, m_ls, m_ps;

  function automatic int lim(int c);
    if (c < MINON) return 0;
    if (c > MAXON) return MAXON;
    return c;
  endfunction

  always @(posedge clk) begin
    bit hw, lw, nh, nl, open_ok;
    if (rst) begin
      m_pos = 0; m_len = 0; m_idle = 0; m_hs = 0; m_ls = 0; m_ps = 0;
    end else begin
      hw = (mode == 2'b10) && (m_pos < m_len);
      lw = (mode == 2'b01) || ((mode == 2'b10) && !hw);
      open_ok = !m_hs && !m_ls && (m_idle >= DT - 1);
      nh = hw && (m_hs || open_ok);
      nl = lw && (m_ls || open_ok);
      if (m_hs || m_ls) m_idle = 0;
      else if (m_idle < DT) m_idle = m_idle + 1;
      m_hs = nh; m_ls = nl;
      m_ps = (m_pos == PER - 1);
      if (m_ps) m_len = lim(int'(duty));
      m_pos = m_ps ? 0 : m_pos + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R1 both enables", int'(hs && ls), 0);
    chk("R10 R2 hs_en timing", int'(hs), int'(m_hs));
    chk("R10 R2 ls_en timing", int'(ls), int'(m_ls));
    chk("R3 strobe timing", int'(ps), int'(m_ps));
  endtask

  task automatic measure(int cmd, int exp_h, int exp_l, string tag);
    int nh = 0, nl = 0, seen = 0;
    mode = 2'b10; duty = CW'(cmd);
    while (seen < 2) begin step(); if (ps) seen++; end
    for (int i = 0; i < PER; i++) begin
      if (i > 0) step();
      nh += int'(hs); nl += int'(ls);
    end
    chk({tag, " hs cycles"}, nh, exp_h);
    chk({tag, " ls cycles"}, nl, exp_l);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd17));
    repeat (4) @(negedge clk);
    chk("R9 reset hs_en", int'(hs), 0);
    chk("R9 reset ls_en", int'(ls), 0);
    chk("R9 reset strobe", int'(ps), 0);
    duty = CW'(20);
    rst = 1'b0;
    k = 0;
    do begin step(); k++; end while (!ps && k < 3 * PER);
    chk("R3 first strobe distance", k, PER);

    measure(20, 20 - DT, PER - 20 - DT, "R10 mid duty");
    measure(MINON, MINON - DT, PER - MINON - DT, "R10 min duty");
    measure(PER + 3, MAXON - DT, PER - MAXON - DT, "R5 clamp");
    measure(MAXON, MAXON - DT, PER - MAXON - DT, "R5 at limit");
    measure(MINON - 1, 0, PER, "R6 deleted pulse");
    measure(0, 0, PER, "R6 zero command");

    // R8 handover while the high side conducts
    measure(20, 20 - DT, PER - 20 - DT, "R10 reload");
    while (!hs) step();
    mode = 2'b01;
    step();
    chk("R8 hs off next cycle", int'(hs), 0);
    chk("R2 ls held in gap", int'(ls), 0);
    for (int i = 1; i < DT; i++) begin
      step();
      chk("R2 gap both off", int'(hs || ls), 0);
    end
    step();
    chk("R8 ls on after gap", int'(ls), 1);

    // R7 off modes
    mode = 2'b00; step();
    chk("R7 off mode", int'(hs || ls), 0);
    mode = 2'b10; repeat (PER) step();
    mode = 2'b11; step();
    chk("R7 second off code", int'(hs || ls), 0);

    // R4 random duty every cycle, rare random mode changes
    for (int i = 0; i < 4000; i++) begin
      duty = CW'($urandom % (PER + 5));
      if ($urandom % 60 == 0) mode = 2'($urandom % 4);
      else if ($urandom % 300 == 0) mode = 2'b10;
      step();
    end
    mode = 2'b10;
    duty = CW'(10);
    for (int i = 0; i < 3 * PER; i++) begin
      if (!ps) duty = CW'($urandom % (PER + 5));
      step();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule